// File: doc/BRIEF.md
# Serial EEPROM I2C Target Engine

This block is the bus-facing half of a byte-addressed serial EEPROM holding 16384 bytes. It runs in the system clock domain and oversamples SCL and SDA. Each line passes through a two-flop synchronizer and a three-sample majority filter before edge detection. From the filtered lines the block finds START and STOP conditions and counts clock pulses within each byte. It checks the device byte against a fixed code and three strap pins, then loads a 14-bit address counter from two address bytes. It drives SDA only by pulling it low, through an open-drain enable.

Each write data byte is handed to a page buffer together with its address, and a commit pulse follows the closing STOP. Reads take their data from a memory read port addressed by the counter. A read can start at the current counter value, at an address loaded just before a repeated START, or run on sequentially across the whole array. While the external write engine reports busy, the block refuses its device byte, so a host can poll for the end of a write cycle. A write-protect pin is strobed once per write transaction and can reject the data.

Top module: `i2c_eeprom_target`

## Requirements
- R1: START (SDA falls while SCL is high) opens a transaction and STOP (SDA rises while SCL is high) closes it. Bytes clocked after reset or STOP with no START before them get no acknowledge.
- R2: The device byte is accepted only when its upper seven bits equal binary 1010 followed by the three strap pins (strap bit 2 first). If it does not match, the block stays silent until the next START.
- R3: An acknowledge is `sda_oe` = 1 during the 9th SCL pulse. It is given for an accepted device byte, for both address bytes and for every accepted write data byte.
- R4: After a write device byte (bit 0 = 0), the first address byte supplies address bits 13..8 from its low six bits. Its top two bits are ignored. The second address byte supplies bits 7..0.
- R5: Each accepted data byte produces a one-cycle `wr_valid` with `wr_addr` set to the counter and `wr_data` set to the byte. The counter's low six bits then step and wrap inside the 64-byte page.
- R6: A STOP that ends a transaction with at least one accepted data byte gives a one-cycle `wr_commit`. A repeated START discards the pending write.
- R7: A read device byte (bit 0 = 1) with no address phase returns the byte at the current counter. The counter advances after every transmitted byte, so a later current-address read continues from there.
- R8: A random read consists of the two address bytes, a repeated START and a read device byte. It returns data from the loaded address.
- R9: Reading continues byte after byte while the host acknowledges, with the counter wrapping from 16383 to 0. After a host NACK, SDA stays released (reads as 0xFF) until STOP.
- R10: While `wr_busy` is high when the device byte completes, that byte is not acknowledged.
- R11: `wp` is strobed on the SCL falling edge that ends the second address byte's acknowledge. If it was high there, the first data byte gets a NACK, no `wr_valid` or `wr_commit` follows, and later changes of `wp` have no effect.
- R12: `sda_oe` is 0 after reset, outputs bits MSB first, and only rises while the filtered SCL is low.
- R13: An SDA pulse lasting one system clock while SCL is high is filtered out and starts no transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_i | input | 3 | Device address strap pins |
| wp_i | input | 1 | Write-protect pin, high blocks writes |
| wr_busy_i | input | 1 | High while the write engine is programming |
| rd_addr | output | 14 | Read port address (the address counter) |
| rd_data | input | 8 | Byte stored at `rd_addr` |
| wr_valid | output | 1 | One-cycle strobe for an accepted data byte |
| wr_addr | output | 14 | Address of the byte given with `wr_valid` |
| wr_data | output | 8 | Data byte given with `wr_valid` |
| wr_commit | output | 1 | One-cycle pulse when a STOP closes a write |

## Verification
The last byte of the array ends in the same system cycle as two other actions: the counter steps from 16383 to 0, and SDA is released for the host's acknowledge. A sequential read that starts at 16382 provokes this, and so does a current-address read after it. The bench judges it by the data that crosses the wrap and the byte read next. A second collision is `wp` changing right next to its strobe edge. The bench raises `wp` just after the address acknowledge ends and expects the data byte still to be accepted. It holds `wp` high across the strobe and expects a NACK, no write strobe and no commit.

// File: rtl/i2ce_pkg.sv
package i2ce_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_DEV, PH_AHI, PH_ALO, PH_WDAT, PH_RDAT, PH_SKIP
  } phase_e;
  localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/i2ce_line_filter.sv
module i2ce_line_filter #(
  parameter int SYNC = 2,
  parameter int TAPS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic filt_o
);
  localparam int CW = $clog2(TAPS + 1);
  localparam int HALF = TAPS / 2;

  logic [SYNC-1:0] sync_q;
  logic [TAPS-1:0] win_q;
  logic [CW-1:0]   ones;
  logic            filt_q;

  always_comb begin
    ones = '0;
    for (int k = 0; k < TAPS; k++) ones = ones + CW'(win_q[k]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      win_q  <= '1;
      filt_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], raw_i};
      win_q  <= {win_q[TAPS-2:0], sync_q[SYNC-1]};
      filt_q <= (ones > CW'(HALF));
    end
  end

  assign filt_o = filt_q;

  // R13: a single odd sample inside a settled window never moves the output
  p_one_sample_ignored_r13: assert property (@(posedge clk) disable iff (rst)
    (win_q == '1 && filt_q) |=> filt_q);
endmodule

// File: rtl/i2ce_bus_events.sv
module i2ce_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise = scl_f & ~scl_q;
  assign scl_fall = ~scl_f & scl_q;
  assign start_ev = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_ev  = scl_f & scl_q & ~sda_q & sda_f;
endmodule

// File: rtl/i2ce_engine.sv
module i2ce_engine
  import i2ce_pkg::*;
#(
  parameter int AW     = 14,
  parameter int PAGE_W = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_ev,
  input  logic          stop_ev,
  input  logic          scl_lvl,
  input  logic          sda_in,
  input  logic [2:0]    strap,
  input  logic          wp,
  input  logic          busy,
  output logic [AW-1:0] rd_addr,
  input  logic [7:0]    rd_data,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          wr_commit,
  output logic          sda_oe
);
  localparam int HI_W = AW - 8;

  phase_e          phase, nxt;
  logic [3:0]      bitcnt;
  logic [7:0]      shreg, txreg;
  logic [AW-1:0]   ctr;
  logic [HI_W-1:0] hi_q;
  logic            wp_q, pend_q, oe_q;
  logic            wv_q, cm_q;
  logic [AW-1:0]   wa_q;
  logic [7:0]      wd_q;
  logic            dev_match;

  assign dev_match = (shreg[7:1] == {DEV_CODE, strap});

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE; nxt <= PH_IDLE; bitcnt <= '0;
      shreg <= '0; txreg <= '0; ctr <= '0; hi_q <= '0;
      wp_q <= 1'b0; pend_q <= 1'b0; oe_q <= 1'b0;
      wv_q <= 1'b0; cm_q <= 1'b0; wa_q <= '0; wd_q <= '0;
    end else begin
      wv_q <= 1'b0;
      cm_q <= 1'b0;
      if (start_ev) begin
        phase  <= PH_DEV;
        bitcnt <= '0;
        oe_q   <= 1'b0;
        pend_q <= 1'b0;
      end else if (stop_ev) begin
        phase  <= PH_IDLE;
        bitcnt <= '0;
        oe_q   <= 1'b0;
        cm_q   <= pend_q;
        pend_q <= 1'b0;
      end else if (phase != PH_IDLE) begin
        if (scl_rise) begin
          if (bitcnt < 4'd8) begin
            shreg  <= {shreg[6:0], sda_in};
            bitcnt <= bitcnt + 4'd1;
          end else if (bitcnt == 4'd8) begin
            bitcnt <= 4'd9;
            if (phase == PH_RDAT) nxt <= sda_in ? PH_SKIP : PH_RDAT;
          end
        end else if (scl_fall) begin
          if (bitcnt == 4'd8) begin
            unique case (phase)
              PH_DEV: begin
                if (dev_match && !busy) begin
                  oe_q <= 1'b1;
                  nxt  <= shreg[0] ? PH_RDAT : PH_AHI;
                end else begin
                  nxt <= PH_SKIP;
                end
              end
              PH_AHI: begin
                oe_q <= 1'b1;
                hi_q <= shreg[HI_W-1:0];
                nxt  <= PH_ALO;
              end
              PH_ALO: begin
                oe_q <= 1'b1;
                ctr  <= {hi_q, shreg};
                nxt  <= PH_WDAT;
              end
              PH_WDAT: begin
                if (!wp_q) begin
                  oe_q   <= 1'b1;
                  wv_q   <= 1'b1;
                  wa_q   <= ctr;
                  wd_q   <= shreg;
                  pend_q <= 1'b1;
                  ctr    <= {ctr[AW-1:PAGE_W], ctr[PAGE_W-1:0] + 1'b1};
                  nxt    <= PH_WDAT;
                end else begin
                  nxt <= PH_SKIP;
                end
              end
              PH_RDAT: begin
                oe_q <= 1'b0;
                ctr  <= ctr + 1'b1;
              end
              default: oe_q <= 1'b0;
            endcase
          end else if (bitcnt == 4'd9) begin
            bitcnt <= '0;
            phase  <= nxt;
            if (phase == PH_ALO) wp_q <= wp;
            if (nxt == PH_RDAT) begin
              txreg <= {rd_data[6:0], 1'b0};
              oe_q  <= ~rd_data[7];
            end else begin
              oe_q <= 1'b0;
            end
          end else if (phase == PH_RDAT && bitcnt != 4'd0) begin
            oe_q  <= ~txreg[7];
            txreg <= {txreg[6:0], 1'b0};
          end
        end
      end
    end
  end

  assign rd_addr   = ctr;
  assign wr_valid  = wv_q;
  assign wr_addr   = wa_q;
  assign wr_data   = wd_q;
  assign wr_commit = cm_q;
  assign sda_oe    = oe_q;

  // R1: a START always reopens the device-byte phase with SDA released
  p_start_opens_r1: assert property (@(posedge clk) disable iff (rst)
    start_ev |=> (phase == PH_DEV && !sda_oe));
  // R1: nothing is driven outside a transaction
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE) |-> !sda_oe);
  // R10: busy write engine means the device byte is refused
  p_busy_refuse_r10: assert property (@(posedge clk) disable iff (rst)
    (scl_fall && bitcnt == 4'd8 && phase == PH_DEV && busy) |=> !sda_oe);
  // R11: a protected transaction never emits write data
  p_wp_blocks_r11: assert property (@(posedge clk) disable iff (rst)
    wv_q |-> !wp_q);
  // R12: SDA is only pulled low while SCL is low
  p_oe_rise_low_r12: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_lvl);
  // R6: commit appears only as the transaction closes
  p_commit_idle_r6: assert property (@(posedge clk) disable iff (rst)
    wr_commit |-> (phase == PH_IDLE));
  // R9: the counter steps by one after each transmitted byte
  p_read_step_r9: assert property (@(posedge clk) disable iff (rst)
    (scl_fall && bitcnt == 4'd8 && phase == PH_RDAT && !start_ev && !stop_ev)
      |=> (ctr == AW'($past(ctr) + 1'b1)));
endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target #(
  parameter int ADDR_W = 14,
  parameter int PAGE_W = 6,
  parameter int SYNC   = 2,
  parameter int TAPS   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [2:0]        strap_i,
  input  logic              wp_i,
  input  logic              wr_busy_i,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              wr_commit
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw_l, filt_l;
  logic scl_rise, scl_fall, start_ev, stop_ev;

  assign raw_l = {scl_i, sda_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    i2ce_line_filter #(.SYNC(SYNC), .TAPS(TAPS)) u_filt (
      .clk(clk), .rst(rst), .raw_i(raw_l[g]), .filt_o(filt_l[g])
    );
  end

  i2ce_bus_events u_ev (
    .clk(clk), .rst(rst), .scl_f(filt_l[1]), .sda_f(filt_l[0]),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  i2ce_engine #(.AW(ADDR_W), .PAGE_W(PAGE_W)) u_eng (
    .clk(clk), .rst(rst),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev),
    .scl_lvl(filt_l[1]), .sda_in(filt_l[0]),
    .strap(strap_i), .wp(wp_i), .busy(wr_busy_i),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_commit(wr_commit), .sda_oe(sda_oe)
  );
endmodule

// File: tb/tb_i2c_eeprom_target.sv
module tb_i2c_eeprom_target;
  localparam int Q = 10;
  localparam logic [7:0] DEV_W = 8'hAA;  // 1010 101 0
  localparam logic [7:0] DEV_R = 8'hAB;
  localparam int NV = 5;
  localparam logic [13:0] V_ADDR [NV] = '{14'd0, 14'd77, 14'd16382, 14'd8191, 14'd16383};
  localparam int V_LEN [NV] = '{1, 3, 4, 2, 2};

  logic clk = 1'b0, rst, m_scl, m_sda, wp, busy;
  logic sda_oe, wr_valid, wr_commit;
  logic [13:0] rd_addr, wr_addr;
  logic [7:0] rd_data, wr_data;
  wire sda_bus = m_sda & ~sda_oe;

  int n_chk = 0, n_err = 0, n_wr = 0, n_cm = 0;
  logic [13:0] cap_a [16];
  logic [7:0]  cap_d [16];
  logic        ak, done = 1'b0;
  logic [7:0]  b;
  logic [13:0] va;

  always #10 clk = ~clk;

  function automatic logic [7:0] memf(input logic [13:0] a);
    return a[7:0] ^ {a[13:8], 2'b10};
  endfunction
  assign rd_data = memf(rd_addr);

  i2c_eeprom_target dut (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .strap_i(3'b101), .wp_i(wp), .wr_busy_i(busy),
    .rd_addr(rd_addr), .rd_data(rd_data), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_commit(wr_commit)
  );

  always @(negedge clk) begin
    if (wr_valid) begin
      if (n_wr < 16) begin cap_a[n_wr] = wr_addr; cap_d[n_wr] = wr_data; end
      n_wr++;
    end
    if (wr_commit) n_cm++;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q);
    m_sda = 1'b0; wq(Q); m_scl = 1'b0; wq(Q);
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; wq(Q); m_scl = 1'b1; wq(Q);
    m_sda = 1'b1; wq(2 * Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic a);
    for (int i = 7; i >= 0; i--) begin
      m_sda = d[i]; wq(Q); m_scl = 1'b1; wq(2 * Q); m_scl = 1'b0; wq(Q);
    end
    m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q);
    a = ~sda_bus;
    wq(Q); m_scl = 1'b0; wq(Q);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q); m_scl = 1'b1; wq(Q); d[i] = sda_bus; wq(Q); m_scl = 1'b0;
    end
    wq(Q); m_sda = ~mack; wq(Q); m_scl = 1'b1; wq(2 * Q); m_scl = 1'b0; wq(Q);
    m_sda = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; m_scl = 1'b1; m_sda = 1'b1; wp = 1'b0; busy = 1'b0;
    wq(5); rst = 1'b0; wq(5);
    chk("R12 reset sda_oe", int'(sda_oe), 0);
    chk("R5 reset wr_valid", int'(wr_valid), 0);

    // vector table: random read, sequential run, then current-address read
    for (int v = 0; v < NV; v++) begin
      va = V_ADDR[v];
      i2c_start();
      send_byte(DEV_W, ak);               chk("R3 dev ack", int'(ak), 1);
      send_byte({2'b11, va[13:8]}, ak);   chk("R4 hi ack", int'(ak), 1);
      send_byte(va[7:0], ak);             chk("R3 lo ack", int'(ak), 1);
      i2c_start();
      send_byte(DEV_R, ak);               chk("R8 read dev ack", int'(ak), 1);
      for (int i = 0; i < V_LEN[v]; i++) begin
        recv_byte(i != V_LEN[v] - 1, b);
        chk("R9 R8 seq data", int'(b), int'(memf(va + 14'(i))));
      end
      i2c_stop();
      i2c_start();
      send_byte(DEV_R, ak);               chk("R7 cur dev ack", int'(ak), 1);
      recv_byte(1'b0, b);
      chk("R7 current read", int'(b), int'(memf(va + 14'(V_LEN[v]))));
      i2c_stop();
    end

    // R13 R1: one-clock SDA glitch, then a byte with no START
    m_sda = 1'b0; wq(1); m_sda = 1'b1; wq(2 * Q);
    m_scl = 1'b0; wq(Q);
    send_byte(DEV_W, ak);  chk("R13 R1 no start ack", int'(ak), 0);
    i2c_stop();

    // R2: wrong strap bits and wrong code
    i2c_start(); send_byte(8'hA4, ak); chk("R2 strap mismatch", int'(ak), 0);
    send_byte(8'h00, ak);              chk("R2 silent after mismatch", int'(ak), 0);
    i2c_stop();
    i2c_start(); send_byte(8'hBA, ak); chk("R2 code mismatch", int'(ak), 0);
    i2c_stop();

    // R5 R6: page write with wrap inside the page (0x013E, 0x013F, 0x0100)
    n_wr = 0; n_cm = 0;
    i2c_start(); send_byte(DEV_W, ak);
    send_byte(8'hC1, ak); send_byte(8'h3E, ak);
    send_byte(8'hA5, ak); chk("R3 data ack", int'(ak), 1);
    send_byte(8'h5A, ak); send_byte(8'h33, ak);
    chk("R6 no commit before stop", n_cm, 0);
    i2c_stop(); wq(2);
    chk("R5 write count", n_wr, 3);
    chk("R5 addr0", int'(cap_a[0]), 14'h013E);
    chk("R5 addr1", int'(cap_a[1]), 14'h013F);
    chk("R5 page wrap addr", int'(cap_a[2]), 14'h0100);
    chk("R5 data2", int'(cap_d[2]), 8'h33);
    chk("R6 commit", n_cm, 1);

    // R6: repeated START discards the pending write
    n_cm = 0;
    i2c_start(); send_byte(DEV_W, ak); send_byte(8'h00, ak); send_byte(8'h10, ak);
    send_byte(8'h77, ak); i2c_start(); send_byte(DEV_R, ak); recv_byte(1'b0, b);
    i2c_stop(); wq(2);
    chk("R6 restart no commit", n_cm, 0);

    // R11: wp high across the strobe rejects the data byte
    n_wr = 0; n_cm = 0; wp = 1'b1;
    i2c_start(); send_byte(DEV_W, ak); send_byte(8'h00, ak); send_byte(8'h20, ak);
    wp = 1'b0;
    send_byte(8'h11, ak); chk("R11 wp nack", int'(ak), 0);
    send_byte(8'h22, ak); chk("R11 later wp ignored", int'(ak), 0);
    i2c_stop(); wq(2);
    chk("R11 no write", n_wr, 0);
    chk("R11 no commit", n_cm, 0);

    // R11: wp rising just after the strobe does not block
    i2c_start(); send_byte(DEV_W, ak); send_byte(8'h00, ak); send_byte(8'h30, ak);
    wp = 1'b1;
    send_byte(8'h44, ak); chk("R11 post-strobe wp accepted", int'(ak), 1);
    i2c_stop(); wq(2); wp = 1'b0;
    chk("R11 post-strobe write", n_wr, 1);

    // R10: busy write engine refuses the device byte, then polling succeeds
    busy = 1'b1;
    i2c_start(); send_byte(DEV_W, ak); chk("R10 busy nack", int'(ak), 0);
    i2c_stop(); busy = 1'b0;
    i2c_start(); send_byte(DEV_W, ak); chk("R10 ready ack", int'(ak), 1);
    i2c_stop();

    // R9: after host NACK the line stays released
    i2c_start(); send_byte(DEV_R, ak); recv_byte(1'b0, b);
    recv_byte(1'b0, b); chk("R9 released after nack", int'(b), 8'hFF);
    i2c_stop();
    chk("R12 idle sda_oe", int'(sda_oe), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule